// File: doc/BRIEF.md
# Conversion Result Offset and Alignment Formatter

This block turns a raw 12-bit conversion result into the 16-bit word that a result register holds. Each result arrives with a group tag. A regular result passes through unchanged and is zero-filled. An injected result first has a programmable offset subtracted from it. There is one offset for each of four injected ranks. The difference can be negative, so the word carries sign-fill bits.

A single alignment control chooses where the 12 data bits sit in the word: at the bottom (right) or at the top (left). The alignment and the group tag are captured together with the result. A change to either one after capture does not alter a word that is already stored. The formatted word is registered and comes with a one-cycle valid strobe.

The offsets are loaded through a simple write port made of an enable, a slot index and data. Bus decoding lies outside this block.

Top module: `adc_result_formatter`

## Requirements
- R1: After reset, `outValid` is 0, `outData` is 0x0000, and all four offset slots hold 0.
- R2: When `ofsWrEn` is high at a rising clock edge, `ofsWrData` is stored in slot `ofsWrIdx`. The new offset applies to results presented in later cycles.
- R3: Regular result (`inInjected`=0) with right alignment (`alignLeft`=0): `outData` = {4'b0000, raw}.
- R4: Regular result with left alignment (`alignLeft`=1): `outData` = {raw, 4'b0000}.
- R5: Injected result (`inInjected`=1) with right alignment: d = {0,raw} − {0,offset[inRank]} computed at 13 bits. Bit 12 of d is the sign, and `outData` = {4{d[12]}, d[11:0]}.
- R6: Injected result with left alignment: `outData` = {d[12], d[11:0], 3'b000}.
- R7: `inRank` (0 to 3) selects which of the four offset slots is subtracted. Each slot holds its own value.
- R8: When `inValid` is high at a rising edge, `outData` and `outValid` update at that same edge. `outValid` is high for exactly the following cycle. Back-to-back valid cycles each produce their own word.
- R9: `alignLeft` and `inInjected` are sampled only with `inValid`. While `inValid` is low, `outData` holds its last value and changes on any input are ignored.
- R10: Boundary values: raw equal to the offset gives 0x0000. Raw 0x000 with offset 0xFFF gives d = −4095, so the right-aligned word is 0xF001 and the left-aligned word is 0x8008.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ofsWrEn | input | 1 | Offset slot write enable |
| ofsWrIdx | input | 2 | Offset slot index to write |
| ofsWrData | input | 12 | Offset value to write |
| inValid | input | 1 | Raw result is present this cycle |
| inRaw | input | 12 | Raw conversion result |
| inInjected | input | 1 | 1 = injected group, 0 = regular group |
| inRank | input | 2 | Injected rank, selects the offset slot |
| alignLeft | input | 1 | 0 = right aligned, 1 = left aligned |
| outValid | output | 1 | One-cycle strobe for a new word |
| outData | output | 16 | Formatted result word |

## Verification
Each word is due at the rising edge that samples `inValid` high, one register deep. The bench drives the inputs at the falling edge and reads `outValid` and `outData` one nanosecond after the next rising edge. One cycle later it checks that `outValid` has dropped and that `outData` still holds the word, even though the alignment and group inputs were toggled in between. An offset write is given its own edge before the result that uses it. Back-to-back results are checked at each consecutive edge.

// File: rtl/fmt_pkg.sv
package fmt_pkg;

  // Result layout selected at capture time: {injected, left}.
  typedef enum logic [1:0] {
    ModeRegRight = 2'b00,
    ModeRegLeft  = 2'b01,
    ModeInjRight = 2'b10,
    ModeInjLeft  = 2'b11
  } fmt_mode_t;

  // Strobes passed from control to datapath.
  typedef struct packed {
    logic      capture;
    fmt_mode_t mode;
  } fmt_strobe_t;

endpackage

// File: rtl/fmt_offset_regs.sv
module fmt_offset_regs #(
  parameter int RawW   = 12,
  parameter int NumOfs = 4,
  localparam int IdxW  = $clog2(NumOfs)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wrEn,
  input  logic [IdxW-1:0] wrIdx,
  input  logic [RawW-1:0] wrData,
  input  logic [IdxW-1:0] rdIdx,
  output logic [RawW-1:0] rdData
);

  logic [RawW-1:0] slotQ [NumOfs];

  for (genvar i = 0; i < NumOfs; i++) begin : g_slot
    logic hit;
    assign hit = wrEn && (wrIdx == IdxW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slotQ[i] <= '0;
      else if (hit) slotQ[i] <= wrData;
    end

    // R2/R7: a slot is untouched unless its own index is written
    a_r7_slot_isolated: assert property (@(posedge clk) disable iff (!rst_n)
      !(wrEn && (wrIdx == IdxW'(i))) |=> $stable(slotQ[i]));
  end

  assign rdData = slotQ[rdIdx];

endmodule

// File: rtl/fmt_ctrl.sv
module fmt_ctrl
  import fmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic        inInjected,
  input  logic        alignLeft,
  output fmt_strobe_t strobe,
  output fmt_mode_t   lastMode,
  output logic        outValid
);

  always_comb begin
    strobe.capture = inValid;
    unique case ({inInjected, alignLeft})
      2'b00:   strobe.mode = ModeRegRight;
      2'b01:   strobe.mode = ModeRegLeft;
      2'b10:   strobe.mode = ModeInjRight;
      default: strobe.mode = ModeInjLeft;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      lastMode <= ModeRegRight;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) lastMode <= strobe.mode;
    end
  end

  // R8: one strobe per accepted result, none otherwise
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  a_r8_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
  // R9: the captured layout only moves on a capture
  a_r9_mode_held: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(lastMode));

endmodule

// File: rtl/fmt_datapath.sv
module fmt_datapath
  import fmt_pkg::*;
#(
  parameter int RawW = 12,
  parameter int OutW = 16,
  localparam int PadW  = OutW - RawW,
  localparam int LPadW = OutW - RawW - 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  fmt_strobe_t     strobe,
  input  fmt_mode_t       lastMode,
  input  logic            outValid,
  input  logic [RawW-1:0] raw,
  input  logic [RawW-1:0] offset,
  output logic [OutW-1:0] outData
);

  logic [RawW:0]   diff;
  logic            sign;
  logic [OutW-1:0] fmtWord;

  assign diff = {1'b0, raw} - {1'b0, offset};
  assign sign = diff[RawW];

  always_comb begin
    unique case (strobe.mode)
      ModeRegRight: fmtWord = {{PadW{1'b0}}, raw};
      ModeRegLeft:  fmtWord = {raw, {PadW{1'b0}}};
      ModeInjRight: fmtWord = {{PadW{sign}}, diff[RawW-1:0]};
      default:      fmtWord = {sign, diff[RawW-1:0], {LPadW{1'b0}}};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              outData <= '0;
    else if (strobe.capture) outData <= fmtWord;
  end

  // R3: regular right-aligned words have an all-zero top
  a_r3_reg_right_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && lastMode == ModeRegRight) |-> (outData[OutW-1:RawW] == '0));
  // R4: regular left-aligned words have an all-zero bottom
  a_r4_reg_left_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && lastMode == ModeRegLeft) |-> (outData[PadW-1:0] == '0));
  // R5: injected right-aligned words carry a uniform sign fill
  a_r5_inj_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && lastMode == ModeInjRight) |->
      ($countones(outData[OutW-1:RawW]) == 0 || $countones(outData[OutW-1:RawW]) == PadW));
  // R6: injected left-aligned words have a zero bottom
  a_r6_inj_left_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && lastMode == ModeInjLeft) |-> (outData[LPadW-1:0] == '0));
  // R9: no capture, no change
  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.capture |=> $stable(outData));

endmodule

// File: rtl/adc_result_formatter.sv
module adc_result_formatter
  import fmt_pkg::*;
#(
  parameter int RawW   = 12,
  parameter int OutW   = 16,
  parameter int NumOfs = 4,
  localparam int IdxW  = $clog2(NumOfs)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ofsWrEn,
  input  logic [IdxW-1:0] ofsWrIdx,
  input  logic [RawW-1:0] ofsWrData,
  input  logic            inValid,
  input  logic [RawW-1:0] inRaw,
  input  logic            inInjected,
  input  logic [IdxW-1:0] inRank,
  input  logic            alignLeft,
  output logic            outValid,
  output logic [OutW-1:0] outData
);

  fmt_strobe_t     strobe;
  fmt_mode_t       lastMode;
  logic [RawW-1:0] offsetSel;

  fmt_offset_regs #(.RawW(RawW), .NumOfs(NumOfs)) u_ofs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (ofsWrEn),
    .wrIdx  (ofsWrIdx),
    .wrData (ofsWrData),
    .rdIdx  (inRank),
    .rdData (offsetSel)
  );

  fmt_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .inValid    (inValid),
    .inInjected (inInjected),
    .alignLeft  (alignLeft),
    .strobe     (strobe),
    .lastMode   (lastMode),
    .outValid   (outValid)
  );

  fmt_datapath #(.RawW(RawW), .OutW(OutW)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .lastMode (lastMode),
    .outValid (outValid),
    .raw      (inRaw),
    .offset   (offsetSel),
    .outData  (outData)
  );

endmodule

// File: tb/adc_result_formatter_test.sv
module adc_result_formatter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ofsWrEn = 1'b0;
  logic [1:0]  ofsWrIdx = '0;
  logic [11:0] ofsWrData = '0;
  logic        inValid = 1'b0;
  logic [11:0] inRaw = '0;
  logic        inInjected = 1'b0;
  logic [1:0]  inRank = '0;
  logic        alignLeft = 1'b0;
  logic        outValid;
  logic [15:0] outData;

  int vecs = 0;
  int bad  = 0;
  logic [11:0] ofsModel [4];

  always #10 clk = ~clk;

  adc_result_formatter uut (
    .clk(clk), .rst_n(rst_n),
    .ofsWrEn(ofsWrEn), .ofsWrIdx(ofsWrIdx), .ofsWrData(ofsWrData),
    .inValid(inValid), .inRaw(inRaw), .inInjected(inInjected),
    .inRank(inRank), .alignLeft(alignLeft),
    .outValid(outValid), .outData(outData)
  );

  function automatic logic [15:0] expectWord(logic [11:0] raw, logic inj,
                                            logic [11:0] ofs, logic left);
    int d;
    logic [12:0] d13;
    if (!inj) return left ? {raw, 4'h0} : {4'h0, raw};
    d = int'(raw) - int'(ofs);
    d13 = d[12:0];
    if (left) return {d13[12], d13[11:0], 3'b000};
    return {{4{d13[12]}}, d13[11:0]};
  endfunction

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeOfs(logic [1:0] idx, logic [11:0] val);
    @(negedge clk);
    ofsWrEn = 1'b1; ofsWrIdx = idx; ofsWrData = val;
    @(negedge clk);
    ofsWrEn = 1'b0;
    ofsModel[idx] = val;
  endtask

  // One result, checked at its due edge, then checked for hold with the
  // layout inputs toggled while idle (R8, R9).
  task automatic applyOne(string req, logic [11:0] raw, logic inj,
                          logic [1:0] rank, logic left);
    logic [15:0] exp;
    exp = expectWord(raw, inj, ofsModel[rank], left);
    @(negedge clk);
    inValid = 1'b1; inRaw = raw; inInjected = inj; inRank = rank; alignLeft = left;
    @(posedge clk); #1;
    check({req, " R8 valid"}, {15'd0, outValid}, 16'd1);
    check(req, outData, exp);
    @(negedge clk);
    inValid = 1'b0; alignLeft = ~left; inInjected = ~inj; inRaw = ~raw;
    @(posedge clk); #1;
    check("R8 valid drop", {15'd0, outValid}, 16'd0);
    check("R9 hold", outData, exp);
  endtask

  task automatic testReset();
    #1;
    check("R1 reset valid", {15'd0, outValid}, 16'd0);
    check("R1 reset data", outData, 16'h0000);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 idle after reset", outData, 16'h0000);
    for (int i = 0; i < 4; i++) ofsModel[i] = '0;
  endtask

  task automatic testZeroOffsets();
    applyOne("R1 zero offset inj", 12'h345, 1'b1, 2'd2, 1'b0);
  endtask

  task automatic testRegular();
    applyOne("R3 reg right", 12'hABC, 1'b0, 2'd0, 1'b0);
    applyOne("R4 reg left",  12'hABC, 1'b0, 2'd0, 1'b1);
    applyOne("R3 reg right max", 12'hFFF, 1'b0, 2'd3, 1'b0);
    applyOne("R4 reg left max",  12'hFFF, 1'b0, 2'd3, 1'b1);
  endtask

  task automatic testInjected();
    writeOfs(2'd0, 12'h100);
    writeOfs(2'd1, 12'h800);
    writeOfs(2'd2, 12'hFFF);
    writeOfs(2'd3, 12'h000);
    applyOne("R5 inj right pos", 12'h300, 1'b1, 2'd0, 1'b0);
    check("R5 literal", expectWord(12'h300, 1'b1, 12'h100, 1'b0), 16'h0200);
    applyOne("R6 inj left pos",  12'h300, 1'b1, 2'd0, 1'b1);
    applyOne("R5 inj right neg", 12'h100, 1'b1, 2'd1, 1'b0);
    applyOne("R6 inj left neg",  12'h100, 1'b1, 2'd1, 1'b1);
    applyOne("R7 rank3 zero ofs", 12'hFFF, 1'b1, 2'd3, 1'b0);
    applyOne("R7 rank3 left", 12'hFFF, 1'b1, 2'd3, 1'b1);
  endtask

  task automatic testBoundary();
    applyOne("R10 equal", 12'h800, 1'b1, 2'd1, 1'b0);
    check("R10 equal literal", outData, 16'h0000);
    applyOne("R10 min right", 12'h000, 1'b1, 2'd2, 1'b0);
    check("R10 min right literal", outData, 16'hF001);
    applyOne("R10 min left", 12'h000, 1'b1, 2'd2, 1'b1);
    check("R10 min left literal", outData, 16'h8008);
  endtask

  task automatic testRewrite();
    writeOfs(2'd0, 12'h050);
    applyOne("R2 rewritten offset", 12'h040, 1'b1, 2'd0, 1'b0);
    check("R2 literal", outData, 16'hFFF0);
    applyOne("R7 other slot kept", 12'h900, 1'b1, 2'd1, 1'b0);
    check("R7 literal", outData, 16'h0100);
  endtask

  task automatic testBackToBack();
    logic [15:0] e0, e1, e2;
    e0 = expectWord(12'h123, 1'b0, ofsModel[0], 1'b1);
    e1 = expectWord(12'h010, 1'b1, ofsModel[1], 1'b0);
    e2 = expectWord(12'h7FF, 1'b1, ofsModel[2], 1'b1);
    @(negedge clk);
    inValid = 1'b1; inRaw = 12'h123; inInjected = 1'b0; inRank = 2'd0; alignLeft = 1'b1;
    @(posedge clk); #1;
    check("R8 b2b 0", outData, e0);
    @(negedge clk);
    inRaw = 12'h010; inInjected = 1'b1; inRank = 2'd1; alignLeft = 1'b0;
    @(posedge clk); #1;
    check("R8 b2b 1", outData, e1);
    check("R8 b2b valid", {15'd0, outValid}, 16'd1);
    @(negedge clk);
    inRaw = 12'h7FF; inInjected = 1'b1; inRank = 2'd2; alignLeft = 1'b1;
    @(posedge clk); #1;
    check("R8 b2b 2", outData, e2);
    @(negedge clk); inValid = 1'b0;
    @(posedge clk); #1;
    check("R8 b2b end", {15'd0, outValid}, 16'd0);
  endtask

  initial begin
    testReset();
    testZeroOffsets();
    testRegular();
    testInjected();
    testBoundary();
    testRewrite();
    testBackToBack();
    repeat (2) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    #(20 * 100000);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

endmodule